// File: doc/BRIEF.md
# Pipelined CORDIC Rotator and Vector Resolver

The block is a fully unrolled CORDIC engine that accepts one sample per clock and returns one result per clock after a fixed delay. Each sample carries signed 16-bit x, y and angle z values and a mode bit. In rotation mode the pair (x, y) is turned by the angle z. Feeding x = A, y = 0 therefore yields A·cos z and A·sin z. In vectoring mode the pair is resolved into its length and its phase, and the phase is added to the incoming z.

The pipeline has three parts. First, a conditioning register moves the sample into the half-plane where the shift-and-add iterations converge, and remembers whether it did so. Next come sixteen micro-rotation stages, each registered, where stage k uses shifts of k bits and a fixed arctangent constant. Last, a correction register multiplies x and y by the inverse of the accumulated CORDIC gain. It then undoes the folding, using the flag that travelled with the sample. Angles are binary: the full 16-bit range covers one turn, so 16384 is a quarter turn and -32768 is a half turn.

Input vectors must have a length of at most 19000 so that the unscaled internal growth fits in 16 bits.

Top module: `cordic_pipe`

## Requirements
- R1: In rotation mode (in_vector = 0) with |in_z| <= 16384, out_x and out_y equal x·cosθ − y·sinθ and x·sinθ + y·cosθ within ±24 LSB, where θ = in_z·π/32768.
- R2: In rotation mode the residual angle on out_z lies within ±8 LSB of zero.
- R3: In vectoring mode (in_vector = 1), out_x equals sqrt(x² + y²) within ±24 LSB and out_y lies within ±16 LSB of zero.
- R4: In vectoring mode, out_z equals in_z + atan2(y, x)·32768/π within ±10 LSB, taken modulo 65536.
- R5: Inputs outside the convergence half-plane still give the R1–R4 results. This covers rotation angles with |in_z| > 16384, including -32768, and vectoring inputs with negative x, including the negative real axis, whose phase is a half turn.
- R6: A sample presented with in_valid high on a rising edge appears with out_valid high exactly 18 rising edges later. Consecutive samples emerge on consecutive cycles in order.
- R7: A cycle with in_valid low produces no out_valid pulse, so gaps in the input stream are kept as gaps in the output.
- R8: Reset, synchronous and active high, clears every valid bit in the pipeline. out_valid is low during reset, and no sample taken before reset ever emerges.
- R9: The mode bit is chosen per sample, so interleaved rotation and vectoring samples each get the result of their own mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Sample strobe |
| in_vector | input | 1 | 0 = rotation, 1 = vectoring |
| in_x | input | 16 | Signed x coordinate |
| in_y | input | 16 | Signed y coordinate |
| in_z | input | 16 | Signed binary angle (32768 = π) |
| out_valid | output | 1 | Result strobe |
| out_x | output | 16 | Gain-corrected x, or magnitude in vectoring |
| out_y | output | 16 | Gain-corrected y, near zero in vectoring |
| out_z | output | 16 | Residual angle, or phase in vectoring |

## Verification
The hardest situation to reach is a folded sample sitting next to an unfolded one of the other mode. Here the per-sample quadrant flag and mode bit must stay aligned with their data for eighteen registers. The stimulus table interleaves rotation and vectoring samples and streams them back to back. Within that stream, angles beyond a quarter turn, the exact -π angle and negative-x vectors sit between ordinary samples. Reset is asserted while four samples are in flight, so the bench can confirm that none of them surfaces.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // Arctangent of 2^-k in binary angle units (32768 = pi), rounded.
  function automatic int atan_bam(input int k);
    case (k)
      0:  return 8192;
      1:  return 4836;
      2:  return 2555;
      3:  return 1297;
      4:  return 651;
      5:  return 326;
      6:  return 163;
      7:  return 81;
      8:  return 41;
      9:  return 20;
      10: return 10;
      11: return 5;
      12: return 3;
      13: return 1;
      14: return 1;
      default: return 0;
    endcase
  endfunction

  // Inverse CORDIC gain for 16 stages, Q15.
  localparam int GAIN_INV_Q15 = 19898;

endpackage

// File: rtl/cordic_fold.sv
module cordic_fold #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 val_i,
  input  logic                 vec_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [DW-1:0] z_i,
  output logic                 val_o,
  output logic                 vec_o,
  output logic                 flip_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [DW-1:0] z_o
);
  localparam logic signed [DW-1:0] QTR = DW'(1 << (DW-2));

  logic flip;

  // Rotation: angle beyond a quarter turn. Vectoring: left half-plane.
  always_comb begin
    if (vec_i) flip = x_i[DW-1];
    else       flip = (z_i > QTR) || (z_i < -QTR);
  end

  always_ff @(posedge clk) begin
    if (rst) val_o <= 1'b0;
    else     val_o <= val_i;
  end

  always_ff @(posedge clk) begin
    vec_o  <= vec_i;
    flip_o <= flip;
    if (vec_i && flip) begin
      x_o <= -x_i;
      y_o <= -y_i;
    end else begin
      x_o <= x_i;
      y_o <= y_i;
    end
    // Rotation fold: subtract a half turn, i.e. invert the angle MSB.
    if (!vec_i && flip) z_o <= {~z_i[DW-1], z_i[DW-2:0]};
    else                z_o <= z_i;
  end

  assert_fold_angle_R5: assert property (@(posedge clk) disable iff (rst)
    (val_o && !vec_o) |-> (z_o <= QTR && z_o >= -QTR));

  assert_fold_halfplane_R5: assert property (@(posedge clk) disable iff (rst)
    (val_o && vec_o) |-> !x_o[DW-1]);

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
  parameter int DW  = 16,
  parameter int IDX = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 val_i,
  input  logic                 vec_i,
  input  logic                 flip_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [DW-1:0] z_i,
  output logic                 val_o,
  output logic                 vec_o,
  output logic                 flip_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [DW-1:0] z_o
);
  localparam logic signed [DW-1:0] ANG = DW'(cordic_pkg::atan_bam(IDX));

  logic                 dir_pos;
  logic signed [DW-1:0] x_sh, y_sh;

  // Rotation drives z to zero, vectoring drives y to zero.
  always_comb begin
    dir_pos = vec_i ? y_i[DW-1] : ~z_i[DW-1];
    x_sh    = x_i >>> IDX;
    y_sh    = y_i >>> IDX;
  end

  always_ff @(posedge clk) begin
    if (rst) val_o <= 1'b0;
    else     val_o <= val_i;
  end

  always_ff @(posedge clk) begin
    vec_o  <= vec_i;
    flip_o <= flip_i;
    if (dir_pos) begin
      x_o <= x_i - y_sh;
      y_o <= y_i + x_sh;
      z_o <= z_i - ANG;
    end else begin
      x_o <= x_i + y_sh;
      y_o <= y_i - x_sh;
      z_o <= z_i + ANG;
    end
  end

  assert_valid_step_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (val_o == $past(val_i)));

  assert_mode_carry_R9: assert property (@(posedge clk) disable iff (rst)
    val_o |-> (vec_o == $past(vec_i) && flip_o == $past(flip_i)));

endmodule

// File: rtl/cordic_unfold.sv
module cordic_unfold #(
  parameter int DW   = 16,
  parameter int GAIN = 19898
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 val_i,
  input  logic                 vec_i,
  input  logic                 flip_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [DW-1:0] y_i,
  input  logic signed [DW-1:0] z_i,
  output logic                 val_o,
  output logic signed [DW-1:0] x_o,
  output logic signed [DW-1:0] y_o,
  output logic signed [DW-1:0] z_o
);
  localparam int                     PW   = 2 * DW;
  localparam logic signed [DW-1:0]   GK   = DW'(GAIN);
  localparam logic signed [PW-1:0]   HALF = PW'(1) <<< (DW-2);
  localparam logic signed [DW-1:0]   YTOL = DW'(16);
  localparam logic signed [DW-1:0]   ZTOL = DW'(8);

  logic signed [PW-1:0] px, py;
  logic signed [DW-1:0] sx, sy;
  logic                 vec_q;

  always_comb begin
    px = x_i * GK;
    py = y_i * GK;
    sx = DW'((px + HALF) >>> (DW-1));
    sy = DW'((py + HALF) >>> (DW-1));
  end

  always_ff @(posedge clk) begin
    if (rst) val_o <= 1'b0;
    else     val_o <= val_i;
  end

  always_ff @(posedge clk) begin
    vec_q <= vec_i;
    if (!vec_i && flip_i) begin
      x_o <= -sx;
      y_o <= -sy;
    end else begin
      x_o <= sx;
      y_o <= sy;
    end
    // Vectoring fold: add back the half turn removed at the input.
    if (vec_i && flip_i) z_o <= {~z_i[DW-1], z_i[DW-2:0]};
    else                 z_o <= z_i;
  end

  assert_vec_y_null_R3: assert property (@(posedge clk) disable iff (rst)
    (val_o && vec_q) |-> (y_o <= YTOL && y_o >= -YTOL));

  assert_rot_z_settle_R2: assert property (@(posedge clk) disable iff (rst)
    (val_o && !vec_q) |-> (z_o <= ZTOL && z_o >= -ZTOL));

endmodule

// File: rtl/cordic_pipe.sv
module cordic_pipe #(
  parameter int DW     = 16,
  parameter int STAGES = 16,
  parameter int GAIN   = cordic_pkg::GAIN_INV_Q15
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_vector,
  input  logic signed [DW-1:0] in_x,
  input  logic signed [DW-1:0] in_y,
  input  logic signed [DW-1:0] in_z,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_x,
  output logic signed [DW-1:0] out_y,
  output logic signed [DW-1:0] out_z
);
  logic                 val_c  [0:STAGES];
  logic                 vec_c  [0:STAGES];
  logic                 flip_c [0:STAGES];
  logic signed [DW-1:0] x_c    [0:STAGES];
  logic signed [DW-1:0] y_c    [0:STAGES];
  logic signed [DW-1:0] z_c    [0:STAGES];

  cordic_fold #(.DW(DW)) u_fold (
    .clk(clk), .rst(rst),
    .val_i(in_valid), .vec_i(in_vector),
    .x_i(in_x), .y_i(in_y), .z_i(in_z),
    .val_o(val_c[0]), .vec_o(vec_c[0]), .flip_o(flip_c[0]),
    .x_o(x_c[0]), .y_o(y_c[0]), .z_o(z_c[0])
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    cordic_stage #(.DW(DW), .IDX(k)) u_stage (
      .clk(clk), .rst(rst),
      .val_i(val_c[k]), .vec_i(vec_c[k]), .flip_i(flip_c[k]),
      .x_i(x_c[k]), .y_i(y_c[k]), .z_i(z_c[k]),
      .val_o(val_c[k+1]), .vec_o(vec_c[k+1]), .flip_o(flip_c[k+1]),
      .x_o(x_c[k+1]), .y_o(y_c[k+1]), .z_o(z_c[k+1])
    );
  end

  cordic_unfold #(.DW(DW), .GAIN(GAIN)) u_unfold (
    .clk(clk), .rst(rst),
    .val_i(val_c[STAGES]), .vec_i(vec_c[STAGES]), .flip_i(flip_c[STAGES]),
    .x_i(x_c[STAGES]), .y_i(y_c[STAGES]), .z_i(z_c[STAGES]),
    .val_o(out_valid), .x_o(out_x), .y_o(out_y), .z_o(out_z)
  );

  assert_reset_quiet_R8: assert property (@(posedge clk)
    $past(rst) |-> !out_valid);

endmodule

// File: tb/cordic_pipe_tb.sv
`timescale 1ns/1ps
module cordic_pipe_tb;
  localparam int NV = 14;
  // {mode, x, y, z}; mode 0 = rotation, 1 = vectoring
  localparam int VEC [NV][4] = '{
    '{0,  18000,      0,      0},
    '{1,  15000,  10000,      0},
    '{0,  18000,      0,   8192},
    '{1,  12000, -14000,      0},
    '{0,      0,  15000,  -8192},
    '{1, -13000,   9000,      0},
    '{0,  12000,   9000,  16384},
    '{1, -16000,  -5000,   1000},
    '{0,  18000,      0,  20000},
    '{1,      0,  17000,      0},
    '{0,  10000, -12000, -25000},
    '{1, -18000,      0,      0},
    '{0,  18000,      0, -32768},
    '{0,  -9000,   7000,  30000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_vector = 1'b0;
  logic signed [15:0] in_x = '0, in_y = '0, in_z = '0;
  logic out_valid;
  logic signed [15:0] out_x, out_y, out_z;

  int checks = 0, fails = 0, cycles = 0, nego = 0, cap_n = 0;
  int cap_x [64], cap_y [64], cap_z [64], cap_t [64];

  always #2.5 clk = ~clk;

  cordic_pipe u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vector(in_vector),
    .in_x(in_x), .in_y(in_y), .in_z(in_z),
    .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_z(out_z)
  );

  always @(negedge clk) begin
    nego++;
    if (out_valid && cap_n < 64) begin
      cap_x[cap_n] = out_x;
      cap_y[cap_n] = out_y;
      cap_z[cap_n] = out_z;
      cap_t[cap_n] = nego;
      cap_n++;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp, input int tol);
    checks++;
    if (act - exp > tol || exp - act > tol) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int wrapd(input int d);
    return ((d % 65536) + 65536 + 32768) % 65536 - 32768;
  endfunction

  task automatic check_sample(input int idx, input int m, input int x, input int y, input int z);
    real pi, th, ex, ey, ez;
    string rq;
    pi = 3.14159265358979;
    if (m == 0) begin
      rq = (z > 16384 || z < -16384) ? "R5" : "R1";
      th = z * pi / 32768.0;
      ex = x * $cos(th) - y * $sin(th);
      ey = x * $sin(th) + y * $cos(th);
      chk(rq, "rot x", cap_x[idx], int'(ex), 24);
      chk(rq, "rot y", cap_y[idx], int'(ey), 24);
      chk("R2", "rot residual z", cap_z[idx], 0, 8);
    end else begin
      rq = (x < 0) ? "R5" : "R3";
      ex = $sqrt(real'(x) * x + real'(y) * y);
      ez = z + $atan2(real'(y), real'(x)) * 32768.0 / pi;
      chk(rq, "vec magnitude", cap_x[idx], int'(ex), 24);
      chk(rq, "vec y", cap_y[idx], 0, 16);
      chk(x < 0 ? "R5" : "R4", "vec phase error", wrapd(cap_z[idx] - int'(ez)), 0, 10);
    end
  endtask

  task automatic drive(input bit v, input int m, input int x, input int y, input int z);
    in_valid  = v;
    in_vector = m[0];
    in_x = 16'(x); in_y = 16'(y); in_z = 16'(z);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    chk("R8", "out_valid in reset", int'(out_valid), 0, 0);
    rst = 1'b0;

    // Back-to-back table stream with interleaved modes (R9).
    base = cap_n;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(1'b1, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
    end
    @(negedge clk);
    drive(1'b0, 0, 0, 0, 0);
    repeat (25) @(negedge clk);
    chk("R6", "stream result count", cap_n - base, NV, 0);
    for (int i = 0; i < NV; i++) begin
      chk("R6", "stream spacing", cap_t[base + i] - cap_t[base], i, 0);
      check_sample(base + i, VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3]);
    end

    // Exact latency (R6).
    @(negedge clk);
    drive(1'b1, 0, 16000, 0, 4096);
    @(negedge clk);
    drive(1'b0, 0, 0, 0, 0);
    repeat (16) @(negedge clk);
    chk("R6", "valid before edge 18", int'(out_valid), 0, 0);
    @(negedge clk);
    chk("R6", "valid at edge 18", int'(out_valid), 1, 0);
    @(negedge clk);
    chk("R6", "single pulse", int'(out_valid), 0, 0);

    // Bubble kept and modes per sample (R7, R9).
    base = cap_n;
    @(negedge clk); drive(1'b1, 0, 0, 14000, 12000);
    @(negedge clk); drive(1'b0, 1, 9000, 9000, 0);
    @(negedge clk); drive(1'b1, 1, -7000, -11000, 0);
    @(negedge clk); drive(1'b0, 0, 0, 0, 0);
    repeat (25) @(negedge clk);
    chk("R7", "bubble result count", cap_n - base, 2, 0);
    chk("R7", "bubble spacing", cap_t[base + 1] - cap_t[base], 2, 0);
    check_sample(base, 0, 0, 14000, 12000);
    check_sample(base + 1, 1, -7000, -11000, 0);

    // Reset with samples in flight (R8).
    base = cap_n;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); drive(1'b1, i % 2, 11000, 3000, 5000);
    end
    @(negedge clk); drive(1'b0, 0, 0, 0, 0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8", "out_valid during reset", int'(out_valid), 0, 0);
    rst = 1'b0;
    repeat (25) @(negedge clk);
    chk("R8", "flushed samples emerging", cap_n - base, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule